// File: doc/BRIEF.md
# Boot-Area Command Decoder

This block sits behind the boot-buffer address window of a flash device and interprets data words written into that window as commands. Three commands are recognised: a warm-reset request, a read-identification command that fills the first three words of the boot buffer with identification bytes, and a two-write page-load sequence. In the page-load sequence, a first write arms the decoder and a second write of zero confirms it.

A confirmed page load raises a request towards the array-read logic. The request carries the current block and page address and stays up until that logic acknowledges it. On the acknowledge the page address moves forward by four and wraps within eight bits. Repeated loads therefore walk through consecutive page groups without software rewriting the page address. The boot buffer itself and the array read are outside the block. It only drives a write port into the buffer and a request/acknowledge pair towards the array.

Top module: `boot_cmd_decoder`

## Requirements
- R1: A write is decoded only when its word address lies in 0x0000..0x01FF or 0x8000..0x800F. A write anywhere else has no effect and leaves an armed sequence armed.
- R2: In the unarmed state, data 0x00F0 makes `warm_rst` high for exactly one cycle, starting the cycle after the write. In that same cycle the page address reads 0 and the decoder is unarmed.
- R3: In the unarmed state, data 0x00E0 arms the decoder. The next decoded write always disarms it, whatever its data.
- R4: When armed, data 0x0000 raises `ld_req` from the next cycle. `ld_blk` then holds the block address captured at the confirming write, and `ld_page` holds the current page address.
- R5: `ld_req`, `ld_blk` and `ld_page` stay unchanged until a cycle in which `ld_ack` is high. In the following cycle `ld_req` is low and `ld_page` equals the old page plus 4, modulo 256.
- R6: When armed, any data other than 0x0000 only disarms. It raises no load, no reset and no identification writes.
- R7: In the unarmed state, data 0x0090 produces boot-buffer writes on three consecutive cycles, starting the next cycle. The writes go to index 0, 1 and 2 with data {0x00, low byte of MFR_ID}, {0x00, low byte of DEV_ID} and {0x00, `wp_lo` as sampled at the command write}.
- R8: In the unarmed state, any data value other than 0x00F0, 0x00E0 and 0x0090 is ignored. It produces no output activity and does not arm the decoder.
- R9: Window writes that arrive while a load request is outstanding, or while identification writes are in progress, are ignored. A `page_set` strobe is also ignored while a load is outstanding.
- R10: A `page_set` pulse while idle loads `page_val` into the page address, and the new value is visible on `ld_page` the next cycle.
- R11: After reset `warm_rst`, `bw_en` and `ld_req` are low, `ld_page` is 0 and the decoder is unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Write data (command value) |
| wp_lo | input | 8 | Low byte of the write-protect status |
| blk_addr | input | 16 | Current block address |
| page_set | input | 1 | Load `page_val` into the page address |
| page_val | input | 8 | New page address |
| ld_ack | input | 1 | Array read done |
| warm_rst | output | 1 | One-cycle warm-reset request |
| bw_en | output | 1 | Boot-buffer word write enable |
| bw_idx | output | 2 | Boot-buffer word index |
| bw_data | output | 16 | Boot-buffer word data |
| ld_req | output | 1 | Page-load request |
| ld_blk | output | 16 | Block address of the load |
| ld_page | output | 8 | Page address (of the load while `ld_req` is high) |

## Verification
On every cycle, assertions check the following:
- the load request and its address are held stable until acknowledged;
- the page step by four with wrap occurs on the acknowledge;
- identification writes advance by one index per cycle with a zero upper byte;
- a reset request always coincides with a cleared page and an unarmed decoder;
- load and identification activity never overlap.

Only the bench scenarios can show which data values and addresses count as commands, and that an armed sequence is discarded by a non-zero second write. They also show that writes during busy periods leave no trace, and that the identification bytes carry the right values.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;

  localparam logic [15:0] CMD_WARM    = 16'h00F0;
  localparam logic [15:0] CMD_ARM     = 16'h00E0;
  localparam logic [15:0] CMD_IDENT   = 16'h0090;
  localparam logic [15:0] CMD_CONFIRM = 16'h0000;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_WARM,
    ACT_ARM,
    ACT_IDENT
  } cmd_act_e;

  function automatic cmd_act_e decode_unarmed(input logic [15:0] d);
    case (d)
      CMD_WARM:  decode_unarmed = ACT_WARM;
      CMD_ARM:   decode_unarmed = ACT_ARM;
      CMD_IDENT: decode_unarmed = ACT_IDENT;
      default:   decode_unarmed = ACT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'h8000, 16'h0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'h800F, 16'h01FF}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [NUM_WIN-1:0] hit_vec;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [ADDR_W-1:0] LO   = WIN_LO[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = WIN_HI[i*ADDR_W +: ADDR_W] - LO;
    logic [ADDR_W-1:0] offs;
    assign offs       = addr - LO;
    assign hit_vec[i] = (offs <= SPAN);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/boot_id_writer.sv
module boot_id_writer #(
  parameter int          DATA_W = 16,
  parameter logic [15:0] MFR_ID = 16'h00EC,
  parameter logic [15:0] DEV_ID = 16'h0040,
  parameter int          WORDS  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [7:0]               wp_lo,
  output logic                     busy,
  output logic                     bw_en,
  output logic [$clog2(WORDS)-1:0] bw_idx,
  output logic [DATA_W-1:0]        bw_data
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       wp_q, wp_d;
  logic [7:0]       byte_sel;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    wp_d  = wp_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      wp_d  = wp_lo;
    end else if (act_q) begin
      if (idx_q == LAST) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      wp_q  <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      wp_q  <= wp_d;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_W'(0): byte_sel = MFR_ID[7:0];
      IDX_W'(1): byte_sel = DEV_ID[7:0];
      default:   byte_sel = wp_q;
    endcase
  end

  assign busy    = act_q;
  assign bw_en   = act_q;
  assign bw_idx  = idx_q;
  assign bw_data = {{(DATA_W-8){1'b0}}, byte_sel};

  // R7: identification words go out in order, one per cycle
  p_id_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && bw_idx != LAST && !start) |=> (bw_en && bw_idx == $past(bw_idx) + 1'b1));

  // R7: only a low byte is ever written
  p_id_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bw_en |-> (bw_data[DATA_W-1:8] == '0));

endmodule

// File: rtl/boot_page_loader.sv
module boot_page_loader #(
  parameter int BLK_W  = 16,
  parameter int PAGE_W = 8,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic              page_set,
  input  logic [PAGE_W-1:0] page_val,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic              ack,
  output logic              req,
  output logic [BLK_W-1:0]  blk,
  output logic [PAGE_W-1:0] page
);

  localparam logic [PAGE_W-1:0] STEP_V = PAGE_W'(STEP);

  logic              req_q, req_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    req_d  = req_q;
    blk_d  = blk_q;
    page_d = page_q;
    if (req_q) begin
      if (ack) begin
        req_d  = 1'b0;
        page_d = page_q + STEP_V;
      end
    end else if (clear) begin
      page_d = '0;
    end else if (start) begin
      req_d = 1'b1;
      blk_d = blk_in;
    end else if (page_set) begin
      page_d = page_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      blk_q  <= '0;
      page_q <= '0;
    end else begin
      req_q  <= req_d;
      blk_q  <= blk_d;
      page_q <= page_d;
    end
  end

  assign req  = req_q;
  assign blk  = blk_q;
  assign page = page_q;

  // R5: request and its address hold until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(page) && $stable(blk)));

  // R5: acknowledge ends the request and steps the page
  p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> (!req && page == $past(page) + STEP_V));

endmodule

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 16,
  parameter int          PAGE_W = 8,
  parameter int          STEP   = 4,
  parameter int          WORDS  = 3,
  parameter logic [15:0] MFR_ID = 16'h00EC,
  parameter logic [15:0] DEV_ID = 16'h0040
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [7:0]               wp_lo,
  input  logic [DATA_W-1:0]        blk_addr,
  input  logic                     page_set,
  input  logic [PAGE_W-1:0]        page_val,
  input  logic                     ld_ack,
  output logic                     warm_rst,
  output logic                     bw_en,
  output logic [$clog2(WORDS)-1:0] bw_idx,
  output logic [DATA_W-1:0]        bw_data,
  output logic                     ld_req,
  output logic [DATA_W-1:0]        ld_blk,
  output logic [PAGE_W-1:0]        ld_page
);

  localparam int NUM_WIN = 2;

  logic     win_hit, id_busy, busy, accept;
  logic     armed_q, armed_d, warm_q, warm_d;
  logic     id_start, ld_start, page_set_ok;
  cmd_act_e act;

  boot_win_decode #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN),
    .WIN_LO ({ADDR_W'(16'h8000), ADDR_W'(16'h0000)}),
    .WIN_HI ({ADDR_W'(16'h800F), ADDR_W'(16'h01FF)})
  ) u_win (
    .addr(wr_addr),
    .hit (win_hit)
  );

  assign busy   = ld_req | id_busy;
  assign accept = wr_en & win_hit & ~busy;
  assign act    = decode_unarmed(16'(wr_data));

  always_comb begin
    armed_d  = armed_q;
    warm_d   = 1'b0;
    id_start = 1'b0;
    ld_start = 1'b0;
    if (accept) begin
      if (armed_q) begin
        armed_d  = 1'b0;
        ld_start = (16'(wr_data) == CMD_CONFIRM);
      end else begin
        case (act)
          ACT_WARM:  begin warm_d = 1'b1; armed_d = 1'b0; end
          ACT_ARM:   armed_d  = 1'b1;
          ACT_IDENT: id_start = 1'b1;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      warm_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      warm_q  <= warm_d;
    end
  end

  assign warm_rst    = warm_q;
  assign page_set_ok = page_set & ~ld_req;

  boot_id_writer #(
    .DATA_W(DATA_W),
    .MFR_ID(MFR_ID),
    .DEV_ID(DEV_ID),
    .WORDS (WORDS)
  ) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (id_start),
    .wp_lo  (wp_lo),
    .busy   (id_busy),
    .bw_en  (bw_en),
    .bw_idx (bw_idx),
    .bw_data(bw_data)
  );

  boot_page_loader #(
    .BLK_W (DATA_W),
    .PAGE_W(PAGE_W),
    .STEP  (STEP)
  ) u_ld (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ld_start),
    .clear   (warm_d),
    .page_set(page_set_ok),
    .page_val(page_val),
    .blk_in  (blk_addr),
    .ack     (ld_ack),
    .req     (ld_req),
    .blk     (ld_blk),
    .page    (ld_page)
  );

  // R2: a reset request always comes with a cleared page and no armed state
  p_warm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> (ld_page == '0 && !armed_q));

  // R9: writes during an outstanding load cannot raise a reset
  p_no_warm_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> !warm_rst);

  // R9: load and identification activity never overlap
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bw_en && ld_req));

  // R3: arming only follows an idle, unarmed decoder
  p_arm_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !$past(busy));

endmodule

// File: tb/tb_boot_cmd_decoder.sv
`timescale 1ns/1ps
module tb_boot_cmd_decoder;

  localparam logic [15:0] MFR = 16'h12EC;
  localparam logic [15:0] DEV = 16'hA55C;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, page_set, ld_ack, warm_rst, bw_en, ld_req;
  logic [15:0] wr_addr, wr_data, blk_addr, bw_data, ld_blk;
  logic [7:0]  wp_lo, page_val, ld_page;
  logic [1:0]  bw_idx;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] pg;

  always #2.5 clk = ~clk;

  boot_cmd_decoder #(.MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_lo(wp_lo), .blk_addr(blk_addr),
    .page_set(page_set), .page_val(page_val), .ld_ack(ld_ack),
    .warm_rst(warm_rst), .bw_en(bw_en), .bw_idx(bw_idx),
    .bw_data(bw_data), .ld_req(ld_req), .ld_blk(ld_blk), .ld_page(ld_page)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_page(input logic [7:0] v);
    page_set = 1'b1; page_val = v;
    @(negedge clk);
    page_set = 1'b0;
  endtask

  task automatic idle_quiet(input string tag);
    chk(tag, {29'd0, warm_rst, bw_en, ld_req}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wp_lo = 8'h5A;
    blk_addr = '0; page_set = 1'b0; page_val = '0; ld_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_quiet("R11 reset outputs");
    chk("R11 reset page", ld_page, 0);
    wr(16'h0004, 16'h0000);
    chk("R11 unarmed after reset", ld_req, 0);

    // R10: page set while idle
    set_page(8'h37);
    chk("R10 page set", ld_page, 8'h37);

    // R2: warm reset pulse clears page
    wr(16'h0100, 16'h00F0);
    chk("R2 warm pulse", warm_rst, 1);
    chk("R2 page cleared", ld_page, 0);
    @(negedge clk);
    chk("R2 pulse ends", warm_rst, 0);

    // R1: window boundary sweep with the reset command
    begin
      logic [15:0] addrs [10] = '{16'h0000, 16'h01FF, 16'h0200, 16'h7FFF, 16'h8000,
                                  16'h800F, 16'h8010, 16'hFFFF, 16'h4000, 16'h8007};
      for (int i = 0; i < 10; i++) begin
        logic exp_hit;
        exp_hit = (addrs[i] <= 16'h01FF) || (addrs[i] >= 16'h8000 && addrs[i] <= 16'h800F);
        wr(addrs[i], 16'h00F0);
        chk($sformatf("R1 window %h", addrs[i]), warm_rst, exp_hit);
        @(negedge clk);
      end
    end

    // R1: write outside the window leaves the armed state intact
    blk_addr = 16'hBEEF;
    wr(16'h0001, 16'h00E0);
    wr(16'h0400, 16'h0090);
    chk("R1 outside ignored", bw_en, 0);
    wr(16'h0001, 16'h0000);
    chk("R1 still armed -> load", ld_req, 1);
    ld_ack = 1'b1; @(negedge clk); ld_ack = 1'b0;

    // R8: unknown data values ignored and never arm
    for (int v = 0; v < 256; v++) begin
      if (v != 16'hF0 && v != 16'hE0 && v != 16'h90) begin
        wr(16'h0010, 16'(v));
        idle_quiet($sformatf("R8 ignore %h", v));
        wr(16'h0020, 16'h0000);
        chk($sformatf("R8 no arm %h", v), ld_req, 0);
      end
    end
    wr(16'h0010, 16'h1234);
    idle_quiet("R8 ignore high data");

    // R7: identification writes
    for (int k = 0; k < 2; k++) begin
      wp_lo = (k == 0) ? 8'h02 : 8'hC3;
      wr(16'h8003, 16'h0090);
      wp_lo = 8'hFF;
      chk("R7 w0 en", {bw_en, bw_idx}, {1'b1, 2'd0});
      chk("R7 w0 data", bw_data, {8'h00, MFR[7:0]});
      @(negedge clk);
      chk("R7 w1 en", {bw_en, bw_idx}, {1'b1, 2'd1});
      chk("R7 w1 data", bw_data, {8'h00, DEV[7:0]});
      @(negedge clk);
      chk("R7 w2 en", {bw_en, bw_idx}, {1'b1, 2'd2});
      chk("R7 w2 data", bw_data, (k == 0) ? 16'h0002 : 16'h00C3);
      @(negedge clk);
      chk("R7 done", bw_en, 0);
    end

    // R3 / R6: armed second write only disarms
    wr(16'h0002, 16'h00E0); wr(16'h0002, 16'h00F0);
    chk("R6 no reset when armed", warm_rst, 0);
    wr(16'h0002, 16'h0000);
    chk("R3 disarmed after F0", ld_req, 0);
    wr(16'h0002, 16'h00E0); wr(16'h0002, 16'h0090);
    chk("R6 no ident when armed", bw_en, 0);
    wr(16'h0002, 16'h0000);
    chk("R3 disarmed after 90", ld_req, 0);
    wr(16'h0002, 16'h00E0); wr(16'h0002, 16'h00E0);
    wr(16'h0002, 16'h0000);
    chk("R3 re-arm disarms", ld_req, 0);

    // R4 / R5: load sweep across the page wrap
    set_page(8'h0D);
    pg = 8'h0D;
    for (int k = 0; k < 70; k++) begin
      blk_addr = 16'(k * 37 + 5);
      wr(16'h800F, 16'h00E0);
      wr(16'h800F, 16'h0000);
      blk_addr = 16'h0;
      chk("R4 req", ld_req, 1);
      chk("R4 blk", ld_blk, 16'(k * 37 + 5));
      chk("R4 page", ld_page, pg);
      for (int h = 0; h < k % 3; h++) begin
        @(negedge clk);
        chk("R5 held", {ld_req, ld_page}, {1'b1, pg});
      end
      ld_ack = 1'b1; @(negedge clk); ld_ack = 1'b0;
      pg = pg + 8'd4;
      chk("R5 released", ld_req, 0);
      chk("R5 page step", ld_page, pg);
    end

    // R9: ignored activity while a load is outstanding
    wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0000);
    set_page(8'h99);
    chk("R9 page_set ignored", ld_page, pg);
    wr(16'h0000, 16'h00F0);
    chk("R9 reset ignored", warm_rst, 0);
    wr(16'h0000, 16'h00E0);
    ld_ack = 1'b1; @(negedge clk); ld_ack = 1'b0;
    pg = pg + 8'd4;
    wr(16'h0000, 16'h0000);
    chk("R9 arm during load ignored", ld_req, 0);
    chk("R9 page after", ld_page, pg);

    // R9: ignored activity while identification runs
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h00E0);
    @(negedge clk); @(negedge clk);
    wr(16'h0000, 16'h0000);
    chk("R9 arm during ident ignored", ld_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule